// File: doc/BRIEF.md
# RAM Block Write-Protection Unit

This unit sits beside an on-chip RAM and decides, for every write, whether the write may reach the array. The RAM is split into fixed 64-byte blocks, and a software-programmed bitmap marks each block as protected or open. Two kinds of writer are watched: the processor data path, which carries a privilege flag, and a set of peripheral DMA write ports, each with a fixed channel number.

A processor write in user mode that lands in a protected block is stopped in its address phase and answered with a two-cycle error response. Privileged processor writes and all reads always pass. DMA writes are checked only when a global enable is set. A DMA write that hits a protected block is stopped, raises a management interrupt, and has its address and channel number recorded. The record holds the first violation until software clears it. Channels that only read RAM are never checked.

Software reaches the bitmap, the enable bit and the fault record through a simple word-indexed register port with a combinational read.

Top module: `ram_wprot_unit`

## Requirements
- R1: The bitmap has one bit per 64-byte block: 256 blocks, block index taken from address bits [13:6]. Block b sits in register word b/32 (words 0 to 7), at bit b%32. A bit of 1 protects the block. All words read back what was written and reset to zero.
- R2: A user-mode (cpuPriv=0) processor write accepted while cpuReady=1 to a protected block asserts cpuWrBlock in that same cycle. In the next cycle the outputs are cpuReady=0 and cpuResp=1. In the cycle after that they are cpuReady=1 and cpuResp=1. cpuResp then returns to 0 if no new violation follows.
- R3: A privileged processor write (cpuPriv=1) is never blocked and never gets an error response, whatever the bitmap holds.
- R4: Processor reads (cpuWrite=0) are never blocked and never get an error response.
- R5: Register word 8 bit 0 is the DMA-check enable, and it resets to 0. While it is 0, no dmaWrBlock bit rises and the interrupt does not fire.
- R6: With the check enabled, a write on a write-capable DMA channel to a protected block asserts that channel's dmaWrBlock bit in the same cycle. mgmtIrq rises on the next cycle. Word 10 then holds the faulting address and word 11 holds the channel number.
- R7: Channels whose bit is clear in WR_MASK never fault and are never blocked. By default these are channels 2 and 5.
- R8: Word 9 is the fault status: bit 0 is the fault flag, which drives mgmtIrq, and bit 1 is the overflow flag. Writing 1 to bit 0 clears both flags. While the fault flag is set, a later violation leaves the recorded address and channel unchanged and only sets the overflow flag.
- R9: When several channels violate in the same cycle, the lowest-numbered channel is recorded and the overflow flag is set.
- R10: When a clear and a single violation arrive in the same cycle, the new violation is recorded, the fault flag stays set and the overflow flag ends up 0.
- R11: Writes from any source to an unprotected block pass without blocking, error or fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuValid | input | 1 | Processor transfer in address phase |
| cpuWrite | input | 1 | Processor transfer is a write |
| cpuPriv | input | 1 | Processor transfer is privileged |
| cpuAddr | input | ADDR_W | Processor byte address |
| cpuReady | output | 1 | Transfer-ready towards the processor |
| cpuResp | output | 1 | Error response towards the processor |
| cpuWrBlock | output | 1 | Suppress the processor write to RAM |
| dmaValid | input | NUM_DMA | Per-channel DMA write request |
| dmaAddr | input | NUM_DMA*ADDR_W | Per-channel DMA byte address, channel i in slice i |
| dmaWrBlock | output | NUM_DMA | Per-channel suppress of the DMA write |
| regWrEn | input | 1 | Register write strobe |
| regIdx | input | REG_IDX_W | Register word index |
| regWdata | input | REG_W | Register write data |
| regRdata | output | REG_W | Register read data (combinational) |
| mgmtIrq | output | 1 | Management interrupt for DMA violations |

## Verification
The checker watches on every cycle that privileged writes and reads are never suppressed, and that read-only channels and a disabled DMA check never block. It also watches that a suppressed processor write always opens the two-cycle error sequence, and that the interrupt follows every DMA block and stays up until a status clear. Which blocks are protected, the exact address and channel captured, the priority among simultaneous violations, and the clear-versus-capture race depend on data values. Only the bench's sweeps over all 256 blocks and its directed DMA scenarios can show those.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  // Processor error-response sequencer states
  typedef enum logic [1:0] {
    ERR_IDLE   = 2'd0,
    ERR_FIRST  = 2'd1,
    ERR_SECOND = 2'd2
  } errState_t;

  // Strobes from the control to the fault record in the datapath
  typedef struct packed {
    logic capture;      // load address and channel, set fault flag
    logic setOverflow;  // set overflow flag
    logic clearFlags;   // software clear of fault and overflow
  } faultStrobe_t;

endpackage

// File: rtl/wprot_datapath.sv
module wprot_datapath
  import wprot_pkg::*;
#(
  parameter int ADDR_W        = 14,
  parameter int BLK_SHIFT     = 6,
  parameter int NUM_DMA       = 6,
  parameter int CH_W          = 3,
  parameter int REG_W         = 32,
  parameter int REG_IDX_W     = 4,
  parameter int NUM_MAP_WORDS = 8,
  parameter int CTRL_IDX      = 8,
  parameter int STATUS_IDX    = 9,
  parameter int FADDR_IDX     = 10,
  parameter int FCHAN_IDX     = 11
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         cpuAddr,
  input  logic [NUM_DMA*ADDR_W-1:0] dmaAddr,
  input  logic                      regWrEn,
  input  logic [REG_IDX_W-1:0]      regIdx,
  input  logic [REG_W-1:0]          regWdata,
  input  faultStrobe_t              strobe,
  input  logic [CH_W-1:0]           capChan,
  output logic                      cpuHit,
  output logic [NUM_DMA-1:0]        dmaHit,
  output logic                      dmaProtEn,
  output logic                      faultFlag,
  output logic [REG_W-1:0]          regRdata
);

  localparam int BLK_W   = ADDR_W - BLK_SHIFT;
  localparam int NUM_BLK = 1 << BLK_W;

  logic [NUM_BLK-1:0] protBits;
  logic               ovfFlag;
  logic [ADDR_W-1:0]  faultAddr;
  logic [CH_W-1:0]    faultChan;
  logic [ADDR_W-1:0]  capAddr;

  // Bitmap lookup for the processor port
  assign cpuHit = protBits[cpuAddr[ADDR_W-1:BLK_SHIFT]];

  // Bitmap lookup per DMA port
  for (genvar g = 0; g < NUM_DMA; g++) begin : g_dmaLookup
    logic [ADDR_W-1:0] chAddr;
    assign chAddr    = dmaAddr[g*ADDR_W +: ADDR_W];
    assign dmaHit[g] = protBits[chAddr[ADDR_W-1:BLK_SHIFT]];
  end

  // Address of the channel chosen for capture
  always_comb begin
    capAddr = '0;
    for (int i = 0; i < NUM_DMA; i++) begin
      if (capChan == CH_W'(i)) capAddr = dmaAddr[i*ADDR_W +: ADDR_W];
    end
  end

  // Bitmap words and control bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      protBits  <= '0;
      dmaProtEn <= 1'b0;
    end else if (regWrEn) begin
      for (int w = 0; w < NUM_MAP_WORDS; w++) begin
        if (regIdx == REG_IDX_W'(w)) protBits[w*REG_W +: REG_W] <= regWdata;
      end
      if (regIdx == REG_IDX_W'(CTRL_IDX)) dmaProtEn <= regWdata[0];
    end
  end

  // Fault record
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultFlag <= 1'b0;
      ovfFlag   <= 1'b0;
      faultAddr <= '0;
      faultChan <= '0;
    end else if (strobe.capture) begin
      faultFlag <= 1'b1;
      ovfFlag   <= strobe.setOverflow;
      faultAddr <= capAddr;
      faultChan <= capChan;
    end else if (strobe.clearFlags) begin
      faultFlag <= 1'b0;
      ovfFlag   <= 1'b0;
    end else if (strobe.setOverflow) begin
      ovfFlag   <= 1'b1;
    end
  end

  // Combinational register read
  always_comb begin
    regRdata = '0;
    for (int w = 0; w < NUM_MAP_WORDS; w++) begin
      if (regIdx == REG_IDX_W'(w)) regRdata = protBits[w*REG_W +: REG_W];
    end
    if (regIdx == REG_IDX_W'(CTRL_IDX))   regRdata = REG_W'(dmaProtEn);
    if (regIdx == REG_IDX_W'(STATUS_IDX)) regRdata = REG_W'({ovfFlag, faultFlag});
    if (regIdx == REG_IDX_W'(FADDR_IDX))  regRdata = REG_W'(faultAddr);
    if (regIdx == REG_IDX_W'(FCHAN_IDX))  regRdata = REG_W'(faultChan);
  end

endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wprot_pkg::*;
#(
  parameter int               NUM_DMA    = 6,
  parameter int               CH_W       = 3,
  parameter int               REG_IDX_W  = 4,
  parameter int               STATUS_IDX = 9,
  parameter logic [NUM_DMA-1:0] WR_MASK  = 6'b011011
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cpuValid,
  input  logic                 cpuWrite,
  input  logic                 cpuPriv,
  input  logic                 cpuHit,
  output logic                 cpuReady,
  output logic                 cpuResp,
  output logic                 cpuWrBlock,
  input  logic [NUM_DMA-1:0]   dmaValid,
  input  logic [NUM_DMA-1:0]   dmaHit,
  input  logic                 dmaProtEn,
  output logic [NUM_DMA-1:0]   dmaWrBlock,
  input  logic                 faultFlag,
  input  logic                 regWrEn,
  input  logic [REG_IDX_W-1:0] regIdx,
  input  logic                 regClrBit,
  output faultStrobe_t         strobe,
  output logic [CH_W-1:0]      capChan
);

  errState_t           errState, errNext;
  logic                cpuViol;
  logic [NUM_DMA-1:0]  dmaViol;
  logic                anyViol;
  logic                multiViol;
  logic                clearReq;

  // Processor side: suppress in the address phase, then error sequence
  assign cpuReady   = (errState != ERR_FIRST);
  assign cpuResp    = (errState != ERR_IDLE);
  assign cpuViol    = cpuValid && cpuReady && cpuWrite && !cpuPriv && cpuHit;
  assign cpuWrBlock = cpuViol;

  always_comb begin
    case (errState)
      ERR_FIRST: errNext = ERR_SECOND;
      default:   errNext = cpuViol ? ERR_FIRST : ERR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errState <= ERR_IDLE;
    else       errState <= errNext;
  end

  // DMA side
  assign dmaViol    = dmaValid & dmaHit & WR_MASK & {NUM_DMA{dmaProtEn}};
  assign dmaWrBlock = dmaViol;
  assign anyViol    = |dmaViol;
  assign multiViol  = ($countones(dmaViol) > 1);
  assign clearReq   = regWrEn && (regIdx == REG_IDX_W'(STATUS_IDX)) && regClrBit;

  // Lowest-numbered violating channel wins the capture
  always_comb begin
    logic found;
    found   = 1'b0;
    capChan = '0;
    for (int i = 0; i < NUM_DMA; i++) begin
      if (dmaViol[i] && !found) begin
        capChan = CH_W'(i);
        found   = 1'b1;
      end
    end
  end

  always_comb begin
    strobe.capture     = anyViol && (!faultFlag || clearReq);
    strobe.setOverflow = anyViol && ((faultFlag && !clearReq) || multiViol);
    strobe.clearFlags  = clearReq;
  end

endmodule

// File: rtl/ram_wprot_unit.sv
module ram_wprot_unit
  import wprot_pkg::*;
#(
  parameter int                 ADDR_W    = 14,
  parameter int                 BLK_SHIFT = 6,
  parameter int                 NUM_DMA   = 6,
  parameter int                 REG_W     = 32,
  parameter int                 REG_IDX_W = 4,
  parameter logic [NUM_DMA-1:0] WR_MASK   = 6'b011011
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cpuValid,
  input  logic                      cpuWrite,
  input  logic                      cpuPriv,
  input  logic [ADDR_W-1:0]         cpuAddr,
  output logic                      cpuReady,
  output logic                      cpuResp,
  output logic                      cpuWrBlock,
  input  logic [NUM_DMA-1:0]        dmaValid,
  input  logic [NUM_DMA*ADDR_W-1:0] dmaAddr,
  output logic [NUM_DMA-1:0]        dmaWrBlock,
  input  logic                      regWrEn,
  input  logic [REG_IDX_W-1:0]      regIdx,
  input  logic [REG_W-1:0]          regWdata,
  output logic [REG_W-1:0]          regRdata,
  output logic                      mgmtIrq
);

  localparam int BLK_W         = ADDR_W - BLK_SHIFT;
  localparam int NUM_BLK       = 1 << BLK_W;
  localparam int NUM_MAP_WORDS = NUM_BLK / REG_W;
  localparam int CTRL_IDX      = NUM_MAP_WORDS;
  localparam int STATUS_IDX    = NUM_MAP_WORDS + 1;
  localparam int FADDR_IDX     = NUM_MAP_WORDS + 2;
  localparam int FCHAN_IDX     = NUM_MAP_WORDS + 3;
  localparam int CH_W          = (NUM_DMA > 1) ? $clog2(NUM_DMA) : 1;

  logic               cpuHit;
  logic [NUM_DMA-1:0] dmaHit;
  logic               dmaProtEn;
  logic               faultFlag;
  faultStrobe_t       strobe;
  logic [CH_W-1:0]    capChan;

  assign mgmtIrq = faultFlag;

  wprot_ctrl #(
    .NUM_DMA(NUM_DMA), .CH_W(CH_W), .REG_IDX_W(REG_IDX_W),
    .STATUS_IDX(STATUS_IDX), .WR_MASK(WR_MASK)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cpuValid(cpuValid), .cpuWrite(cpuWrite), .cpuPriv(cpuPriv), .cpuHit(cpuHit),
    .cpuReady(cpuReady), .cpuResp(cpuResp), .cpuWrBlock(cpuWrBlock),
    .dmaValid(dmaValid), .dmaHit(dmaHit), .dmaProtEn(dmaProtEn),
    .dmaWrBlock(dmaWrBlock), .faultFlag(faultFlag),
    .regWrEn(regWrEn), .regIdx(regIdx), .regClrBit(regWdata[0]),
    .strobe(strobe), .capChan(capChan)
  );

  wprot_datapath #(
    .ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT), .NUM_DMA(NUM_DMA), .CH_W(CH_W),
    .REG_W(REG_W), .REG_IDX_W(REG_IDX_W), .NUM_MAP_WORDS(NUM_MAP_WORDS),
    .CTRL_IDX(CTRL_IDX), .STATUS_IDX(STATUS_IDX),
    .FADDR_IDX(FADDR_IDX), .FCHAN_IDX(FCHAN_IDX)
  ) dp_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .dmaAddr(dmaAddr),
    .regWrEn(regWrEn), .regIdx(regIdx), .regWdata(regWdata),
    .strobe(strobe), .capChan(capChan),
    .cpuHit(cpuHit), .dmaHit(dmaHit), .dmaProtEn(dmaProtEn),
    .faultFlag(faultFlag), .regRdata(regRdata)
  );

endmodule

// File: rtl/wprot_checker.sv
module wprot_checker #(
  parameter int                 NUM_DMA    = 6,
  parameter int                 REG_IDX_W  = 4,
  parameter int                 STATUS_IDX = 9,
  parameter logic [NUM_DMA-1:0] WR_MASK    = 6'b011011
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cpuValid,
  input logic                 cpuWrite,
  input logic                 cpuPriv,
  input logic                 cpuReady,
  input logic                 cpuResp,
  input logic                 cpuWrBlock,
  input logic [NUM_DMA-1:0]   dmaWrBlock,
  input logic                 dmaProtEn,
  input logic                 regWrEn,
  input logic [REG_IDX_W-1:0] regIdx,
  input logic                 regClrBit,
  input logic                 mgmtIrq
);

  logic swClear;
  assign swClear = regWrEn && (regIdx == REG_IDX_W'(STATUS_IDX)) && regClrBit;

  assert_err_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    cpuWrBlock |=> (!cpuReady && cpuResp));

  assert_err_second_R2: assert property (@(posedge clk) disable iff (!rstN)
    !cpuReady |=> (cpuReady && cpuResp));

  assert_err_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuReady) |-> $past(cpuValid && cpuWrite && !cpuPriv));

  assert_priv_pass_R3: assert property (@(posedge clk) disable iff (!rstN)
    cpuPriv |-> !cpuWrBlock);

  assert_read_pass_R4: assert property (@(posedge clk) disable iff (!rstN)
    !cpuWrite |-> !cpuWrBlock);

  assert_dma_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    !dmaProtEn |-> (dmaWrBlock == '0));

  assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dmaWrBlock != '0) |=> mgmtIrq);

  assert_readonly_chan_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((dmaWrBlock & ~WR_MASK) == '0));

  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (mgmtIrq && !swClear) |=> mgmtIrq);

  assert_irq_src_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mgmtIrq) |-> $past(dmaWrBlock != '0));

endmodule

bind ram_wprot_unit wprot_checker #(
  .NUM_DMA(NUM_DMA), .REG_IDX_W(REG_IDX_W),
  .STATUS_IDX(STATUS_IDX), .WR_MASK(WR_MASK)
) chk_i (
  .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
  .cpuPriv(cpuPriv), .cpuReady(cpuReady), .cpuResp(cpuResp),
  .cpuWrBlock(cpuWrBlock), .dmaWrBlock(dmaWrBlock), .dmaProtEn(dmaProtEn),
  .regWrEn(regWrEn), .regIdx(regIdx), .regClrBit(regWdata[0]), .mgmtIrq(mgmtIrq)
);

// File: tb/ram_wprot_unit_tb_top.sv
module ram_wprot_unit_tb_top;

  localparam int ADDR_W  = 14;
  localparam int NUM_DMA = 6;
  localparam int NBLK    = 256;
  localparam logic [NUM_DMA-1:0] MASK = 6'b011011;
  localparam int CTRL = 8, STAT = 9, FADDR = 10, FCHAN = 11;

  logic                      clk = 1'b0;
  logic                      rstN = 1'b0;
  logic                      cpuValid = 0, cpuWrite = 0, cpuPriv = 0;
  logic [ADDR_W-1:0]         cpuAddr = '0;
  logic                      cpuReady, cpuResp, cpuWrBlock;
  logic [NUM_DMA-1:0]        dmaValid = '0;
  logic [NUM_DMA*ADDR_W-1:0] dmaAddr = '0;
  logic [NUM_DMA-1:0]        dmaWrBlock;
  logic                      regWrEn = 0;
  logic [3:0]                regIdx = '0;
  logic [31:0]               regWdata = '0;
  logic [31:0]               regRdata;
  logic                      mgmtIrq;

  int nChecks = 0;
  int nErrors = 0;

  always #5 clk = ~clk;

  ram_wprot_unit dut_i (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuPriv(cpuPriv), .cpuAddr(cpuAddr), .cpuReady(cpuReady), .cpuResp(cpuResp),
    .cpuWrBlock(cpuWrBlock), .dmaValid(dmaValid), .dmaAddr(dmaAddr),
    .dmaWrBlock(dmaWrBlock), .regWrEn(regWrEn), .regIdx(regIdx),
    .regWdata(regWdata), .regRdata(regRdata), .mgmtIrq(mgmtIrq)
  );

  function automatic logic [31:0] patWord(input int w);
    return 32'h9E37_79B9 * 32'(w + 1);
  endfunction

  function automatic logic isProt(input int b);
    logic [31:0] wv;
    wv = patWord(b / 32);
    return wv[b % 32];
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input int idx, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regIdx = 4'(idx); regWdata = d;
    @(negedge clk);
    regWrEn = 0; regWdata = '0;
  endtask

  task automatic regRead(input int idx, output logic [31:0] d);
    regIdx = 4'(idx);
    #1 d = regRdata;
  endtask

  task automatic cpuAccess(input logic [ADDR_W-1:0] a, input logic wr,
                           input logic pv, input logic expBlk, input string tag);
    @(negedge clk);
    cpuValid = 1; cpuWrite = wr; cpuPriv = pv; cpuAddr = a;
    #1 chk(32'(cpuWrBlock), 32'(expBlk), {tag, " block"});
    @(negedge clk);
    cpuValid = 0; cpuWrite = 0; cpuPriv = 0;
    if (expBlk) begin
      chk(32'({cpuReady, cpuResp}), 32'b01, "R2 error first cycle");
      @(negedge clk);
      chk(32'({cpuReady, cpuResp}), 32'b11, "R2 error second cycle");
      @(negedge clk);
      chk(32'({cpuReady, cpuResp}), 32'b10, "R2 error ends");
    end else begin
      chk(32'({cpuReady, cpuResp}), 32'b10, {tag, " no error"});
    end
  endtask

  task automatic dmaOne(input int ch, input logic [ADDR_W-1:0] a);
    dmaValid = '0;
    dmaValid[ch] = 1'b1;
    dmaAddr[ch*ADDR_W +: ADDR_W] = a;
  endtask

  task automatic finishRun;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    int pb, ub, pb2;
    logic [ADDR_W-1:0] aA, aB;

    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // Reset state (R1, R5, R8)
    for (int w = 0; w < 12; w++) begin
      regRead(w, rd);
      chk(rd, 32'h0, "R1 reset register value");
    end
    chk(32'({cpuReady, cpuResp, mgmtIrq}), 32'b100, "R2 reset handshake and irq");

    // Program bitmap and read back (R1)
    for (int w = 0; w < 8; w++) regWrite(w, patWord(w));
    for (int w = 0; w < 8; w++) begin
      regRead(w, rd);
      chk(rd, patWord(w), "R1 bitmap readback");
    end

    // Sweep all blocks: user write, privileged write, read (R1 R2 R3 R4 R11)
    for (int b = 0; b < NBLK; b++) begin
      logic [ADDR_W-1:0] a;
      a = ADDR_W'(b * 64 + (b % 64));
      cpuAccess(a, 1'b1, 1'b0, isProt(b), isProt(b) ? "R1 user write" : "R11 user write open");
      cpuAccess(a, 1'b1, 1'b1, 1'b0, "R3 privileged write");
      cpuAccess(a, 1'b0, 1'b0, 1'b0, "R4 user read");
    end

    pb = -1; pb2 = -1; ub = -1;
    for (int b = 0; b < NBLK; b++) begin
      if (isProt(b) && pb < 0) pb = b;
      else if (isProt(b) && pb2 < 0) pb2 = b;
      if (!isProt(b) && ub < 0) ub = b;
    end
    aA = ADDR_W'(pb * 64 + 12);
    aB = ADDR_W'(pb2 * 64 + 40);

    // DMA check disabled (R5)
    for (int ch = 0; ch < NUM_DMA; ch++) begin
      @(negedge clk);
      dmaOne(ch, aA);
      #1 chk(32'(dmaWrBlock), 32'h0, "R5 disabled no block");
      @(negedge clk);
      dmaValid = '0;
      chk(32'(mgmtIrq), 32'h0, "R5 disabled no irq");
    end

    regWrite(CTRL, 32'h1);
    regRead(CTRL, rd);
    chk(rd, 32'h1, "R5 enable readback");

    // Each channel to a protected block (R6 R7 R8)
    for (int ch = 0; ch < NUM_DMA; ch++) begin
      logic [ADDR_W-1:0] a;
      a = ADDR_W'(pb * 64 + ch * 4);
      @(negedge clk);
      dmaOne(ch, a);
      #1 chk(32'(dmaWrBlock), MASK[ch] ? (32'h1 << ch) : 32'h0,
             MASK[ch] ? "R6 channel block" : "R7 read-only channel");
      @(negedge clk);
      dmaValid = '0;
      chk(32'(mgmtIrq), 32'(MASK[ch]), MASK[ch] ? "R6 irq" : "R7 no irq");
      if (MASK[ch]) begin
        regRead(FADDR, rd); chk(rd, 32'(a), "R6 fault address");
        regRead(FCHAN, rd); chk(rd, 32'(ch), "R6 fault channel");
        regRead(STAT, rd);  chk(rd, 32'h1, "R8 status after first fault");
        regWrite(STAT, 32'h1);
        chk(32'(mgmtIrq), 32'h0, "R8 clear drops irq");
      end
    end

    // DMA to open block (R11)
    @(negedge clk);
    dmaOne(0, ADDR_W'(ub * 64 + 8));
    #1 chk(32'(dmaWrBlock), 32'h0, "R11 dma open block");
    @(negedge clk);
    dmaValid = '0;
    chk(32'(mgmtIrq), 32'h0, "R11 dma open no irq");

    // Later violation only sets overflow (R8)
    @(negedge clk); dmaOne(0, aA);
    @(negedge clk); dmaOne(3, aB);
    @(negedge clk); dmaValid = '0;
    regRead(STAT, rd);  chk(rd, 32'h3, "R8 overflow set");
    regRead(FADDR, rd); chk(rd, 32'(aA), "R8 first address held");
    regRead(FCHAN, rd); chk(rd, 32'h0, "R8 first channel held");
    regWrite(STAT, 32'h1);
    regRead(STAT, rd);  chk(rd, 32'h0, "R8 clear both flags");

    // Simultaneous violations (R9)
    @(negedge clk);
    dmaValid = '0;
    dmaValid[4] = 1'b1; dmaAddr[4*ADDR_W +: ADDR_W] = aB;
    dmaValid[1] = 1'b1; dmaAddr[1*ADDR_W +: ADDR_W] = aA;
    #1 chk(32'(dmaWrBlock), 32'h12, "R9 both blocked");
    @(negedge clk); dmaValid = '0;
    regRead(FCHAN, rd); chk(rd, 32'h1, "R9 lowest channel");
    regRead(FADDR, rd); chk(rd, 32'(aA), "R9 lowest address");
    regRead(STAT, rd);  chk(rd, 32'h3, "R9 overflow set");

    // Clear and violation in the same cycle (R10)
    @(negedge clk);
    regWrEn = 1; regIdx = 4'(STAT); regWdata = 32'h1;
    dmaOne(3, aB);
    @(negedge clk);
    regWrEn = 0; regWdata = '0; dmaValid = '0;
    regRead(STAT, rd);  chk(rd, 32'h1, "R10 fault kept, overflow cleared");
    regRead(FADDR, rd); chk(rd, 32'(aB), "R10 new address");
    regRead(FCHAN, rd); chk(rd, 32'h3, "R10 new channel");
    chk(32'(mgmtIrq), 32'h1, "R10 irq stays");

    // Unprotect the block and retry (R1 R11)
    regWrite(pb / 32, patWord(pb / 32) & ~(32'h1 << (pb % 32)));
    cpuAccess(aA, 1'b1, 1'b0, 1'b0, "R1 cleared bit opens block");

    finishRun();
  end

endmodule